// File: doc/BRIEF.md
# Wait-for-Interrupt Clock Gate Controller

This block derives a gated core clock from a free-running clock, so that a processor core can be halted while it waits for an interrupt and started again when there is work to do. The core reports that it is idling in wait-for-interrupt on a standby input. The block stops the core clock only when that standby input is high, the debug clock enable is low and no wake source is pending.

Three wake sources are registered on the free-running clock before they take part in the decision: an active-low fast interrupt, an active-low normal interrupt and an active-high external debug request. The debug clock enable does not pass through any register. It opens the gate directly, so the core runs on every debug clock tick and a debugger can always reach the core's debug logic to force it out of the idle state. The output is formed by an enable latch that is transparent while the free-running clock is low, followed by an AND with that clock. Every high pulse on the output is therefore a full, unshortened high phase of the source clock.

Top module: `wfi_clock_gate`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high, the stop state is cleared and `gclk` follows `clk` from the next `clk` rising edge onward, whatever the other inputs are.
- R2: When `standby_wfi` is 1, `dbg_tck_en` is 0 and no wake source is active, the `gclk` high phase after the sampling `clk` edge is still complete, and `gclk` shows no rising edge from the next `clk` rising edge onward for as long as that holds.
- R3: When `standby_wfi` goes to 0 while the clock is stopped, the stop state clears at the next `clk` edge and `gclk` rises at the `clk` edge after that.
- R4: Each wake source (`fiq_n` = 0, `irq_n` = 0, `dbg_req` = 1) passes through one register. With the default depth, a source sampled at `clk` edge A clears the stop state at edge A+1, and `gclk` first rises at edge A+2.
- R5: `dbg_tck_en` drives the gate with no register stage. If it is raised while `clk` is low and the clock is stopped, `gclk` rises at the very next `clk` rising edge.
- R6: Changes of `dbg_tck_en` while `clk` is high do not change `gclk` during that high phase. They take effect only after `clk` falls.
- R7: `gclk` rises only together with `clk`, and every `gclk` high pulse lasts exactly one full `clk` high phase.
- R8: After the last wake source is withdrawn with `standby_wfi` still 1 and `dbg_tck_en` 0, the clock stops again. With the default depth, a withdrawal sampled at edge A leaves `gclk` low from edge A+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running source clock |
| rst | input | 1 | Synchronous active-high reset; keeps the clock running |
| standby_wfi | input | 1 | Core reports that it is idle in wait-for-interrupt |
| dbg_tck_en | input | 1 | Debug clock enable; opens the gate combinationally |
| fiq_n | input | 1 | Fast interrupt request, active low (wake source) |
| irq_n | input | 1 | Normal interrupt request, active low (wake source) |
| dbg_req | input | 1 | External debug request, active high (wake source) |
| gclk | output | 1 | Gated core clock |

## Verification
The assertions assume that `clk` runs freely with a fixed period and that `rst` is high at the first edge. They also assume that `standby_wfi` and the three wake sources only change while `clk` is low, away from its rising edge. The stimulus follows this by driving those inputs half a nanosecond after each falling edge. `dbg_tck_en` is the only input that may change at any point in the cycle. The bench deliberately moves it inside the `clk` high phase, so the latch hold and the pulse-width monitor are tested against the case the gate is built for.

// File: rtl/wfi_gate_pkg.sv
package wfi_gate_pkg;

  // Wake sources, all in active-high form.
  typedef struct packed {
    logic fiq;
    logic irq;
    logic dbg;
  } wake_src_t;

  localparam int WAKE_W = $bits(wake_src_t);

  function automatic logic any_src(input wake_src_t s);
    return |s;
  endfunction

endpackage

// File: rtl/wfi_wake_sync.sv
module wfi_wake_sync
  import wfi_gate_pkg::*;
#(
  parameter int STAGES = 1
) (
  input  logic      clk,
  input  logic      rst,
  input  wake_src_t src_raw,
  output logic      wake_any
);

  localparam int LAST = STAGES - 1;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    wake_src_t q;
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= src_raw;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= g_stage[g-1].q;
      end
    end
  end

  assign wake_any = any_src(g_stage[LAST].q);

endmodule

// File: rtl/wfi_stop_reg.sv
module wfi_stop_reg (
  input  logic clk,
  input  logic rst,
  input  logic standby,
  input  logic wake_any,
  output logic stop_q
);

  // Reset forces the clock on; stop only when idle and nothing wakes.
  always_ff @(posedge clk) begin
    if (rst) stop_q <= 1'b0;
    else     stop_q <= standby & ~wake_any;
  end

endmodule

// File: rtl/wfi_gate_cell.sv
module wfi_gate_cell (
  input  logic clk_free,
  input  logic enable,
  output logic en_held,
  output logic clk_out
);

  // Transparent while the source clock is low, frozen while it is high.
  always_latch begin
    if (!clk_free) en_held = enable;
  end

  assign clk_out = clk_free & en_held;

endmodule

// File: rtl/wfi_clock_gate.sv
module wfi_clock_gate
  import wfi_gate_pkg::*;
#(
  parameter int WAKE_STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic standby_wfi,
  input  logic dbg_tck_en,
  input  logic fiq_n,
  input  logic irq_n,
  input  logic dbg_req,
  output logic gclk
);

  wake_src_t src;
  logic      wake_any;
  logic      stop_q;
  logic      gate_en;
  logic      gate_open;

  always_comb begin
    src.fiq = ~fiq_n;
    src.irq = ~irq_n;
    src.dbg = dbg_req;
  end

  wfi_wake_sync #(.STAGES(WAKE_STAGES)) u_wake (
    .clk      (clk),
    .rst      (rst),
    .src_raw  (src),
    .wake_any (wake_any)
  );

  wfi_stop_reg u_stop (
    .clk      (clk),
    .rst      (rst),
    .standby  (standby_wfi),
    .wake_any (wake_any),
    .stop_q   (stop_q)
  );

  // Debug clock enable bypasses every register on purpose.
  assign gate_en = ~stop_q | dbg_tck_en;

  wfi_gate_cell u_cell (
    .clk_free (clk),
    .enable   (gate_en),
    .en_held  (gate_open),
    .clk_out  (gclk)
  );

endmodule

// File: rtl/wfi_clock_gate_chk.sv
module wfi_clock_gate_chk (
  input logic clk,
  input logic rst,
  input logic standby_wfi,
  input logic dbg_tck_en,
  input logic gclk,
  input logic stop_q,
  input logic wake_any,
  input logic gate_open
);

  logic open_at_rise;

  always_ff @(posedge clk) open_at_rise <= gate_open;

  p_reset_runs_r1: assert property (@(posedge clk)
    rst |=> !stop_q)
    else $error("reset left clock stopped");

  p_stop_closes_r2: assert property (@(posedge clk) disable iff (rst)
    (stop_q && !dbg_tck_en) |-> !gate_open)
    else $error("gate open while stopped");

  p_awake_runs_r3: assert property (@(posedge clk) disable iff (rst)
    !standby_wfi |=> !stop_q)
    else $error("stopped without standby");

  p_wake_restarts_r4: assert property (@(posedge clk) disable iff (rst)
    wake_any |=> !stop_q)
    else $error("wake did not clear stop");

  p_dbg_opens_r5: assert property (@(posedge clk) disable iff (rst)
    dbg_tck_en |-> gate_open)
    else $error("debug enable did not open gate");

  p_hold_high_r6: assert property (@(negedge clk) disable iff (rst)
    gate_open == open_at_rise)
    else $error("enable moved during high phase");

  always @(posedge gclk) begin
    p_gclk_in_high_r7: assert (clk)
      else $error("gated clock rose while source low");
  end

endmodule

bind wfi_clock_gate wfi_clock_gate_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .standby_wfi (standby_wfi),
  .dbg_tck_en  (dbg_tck_en),
  .gclk        (gclk),
  .stop_q      (stop_q),
  .wake_any    (wake_any),
  .gate_open   (gate_open)
);

// File: tb/wfi_clock_gate_test.sv
`timescale 1ns/1ps
module wfi_clock_gate_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic standby_wfi = 1'b0;
  logic dbg_tck_en = 1'b0;
  logic fiq_n = 1'b1;
  logic irq_n = 1'b1;
  logic dbg_req = 1'b0;
  logic gclk;

  int total = 0;
  int bad = 0;
  int gedges = 0;
  int bad_rise = 0;
  int bad_width = 0;
  bit done = 0;
  realtime t_rise = 0.0;

  always #2.5 clk = ~clk;

  wfi_clock_gate uut (
    .clk (clk), .rst (rst), .standby_wfi (standby_wfi), .dbg_tck_en (dbg_tck_en),
    .fiq_n (fiq_n), .irq_n (irq_n), .dbg_req (dbg_req), .gclk (gclk)
  );

  // R7 monitor: rises only with clk, full high-phase width.
  always @(posedge gclk) begin
    gedges++;
    t_rise = $realtime;
    if (!clk) bad_rise++;
  end
  always @(negedge gclk) begin
    if (($realtime - t_rise) > 2.51 || ($realtime - t_rise) < 2.49) bad_width++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic at_rise();
    @(posedge clk); #1;
  endtask

  task automatic at_fall();
    @(negedge clk); #0.5;
  endtask

  task automatic enter_stop();
    at_fall();
    standby_wfi = 1'b1; dbg_tck_en = 1'b0;
    fiq_n = 1'b1; irq_n = 1'b1; dbg_req = 1'b0;
    at_rise(); at_rise();
  endtask

  task automatic test_reset();
    int e0;
    standby_wfi = 1'b1;
    at_rise(); at_rise();
    e0 = gedges;
    for (int i = 0; i < 4; i++) begin
      at_rise();
      check(gclk == 1'b1, "R1", "gclk in reset", gclk, 1);
    end
    check(gedges - e0 == 4, "R1", "edges during reset", gedges - e0, 4);
    at_fall();
    rst = 1'b0; standby_wfi = 1'b0;
    at_rise();
    check(gclk == 1'b1, "R1", "gclk after reset", gclk, 1);
  endtask

  task automatic test_stop();
    int e0;
    at_fall();
    standby_wfi = 1'b1;
    at_rise();
    check(gclk == 1'b1, "R2", "last pulse complete", gclk, 1);
    at_rise();
    check(gclk == 1'b0, "R2", "gclk stopped", gclk, 0);
    e0 = gedges;
    for (int i = 0; i < 8; i++) at_rise();
    check(gedges == e0, "R2", "edges while stopped", gedges - e0, 0);
  endtask

  task automatic test_standby_low();
    enter_stop();
    at_fall();
    standby_wfi = 1'b0;
    at_rise();
    check(gclk == 1'b0, "R3", "gclk at first edge", gclk, 0);
    at_rise();
    check(gclk == 1'b1, "R3", "gclk restarted", gclk, 1);
  endtask

  task automatic test_wake(input int which);
    enter_stop();
    at_fall();
    if (which == 0) fiq_n = 1'b0;
    else if (which == 1) irq_n = 1'b0;
    else dbg_req = 1'b1;
    at_rise();
    check(gclk == 1'b0, "R4", "gclk at sampling edge", which, 0);
    at_rise();
    check(gclk == 1'b0, "R4", "gclk at edge A+1", which, 0);
    at_rise();
    check(gclk == 1'b1, "R4", "gclk at edge A+2", which, 1);
    at_rise();
    check(gclk == 1'b1, "R4", "gclk keeps running", which, 1);
    at_fall();
    fiq_n = 1'b1; irq_n = 1'b1; dbg_req = 1'b0;
    at_rise();
    check(gclk == 1'b1, "R8", "gclk at withdrawal edge", gclk, 1);
    at_rise();
    check(gclk == 1'b1, "R8", "last pulse after withdrawal", gclk, 1);
    at_rise();
    check(gclk == 1'b0, "R8", "stopped again", gclk, 0);
  endtask

  task automatic test_dbg_comb();
    enter_stop();
    at_fall();
    dbg_tck_en = 1'b1;
    at_rise();
    check(gclk == 1'b1, "R5", "gclk at next edge", gclk, 1);
    at_rise();
    check(gclk == 1'b1, "R5", "gclk keeps running", gclk, 1);
    at_fall();
    dbg_tck_en = 1'b0;
    at_rise();
    check(gclk == 1'b0, "R5", "gclk stops after drop", gclk, 0);
  endtask

  task automatic test_dbg_high_phase();
    int e0;
    enter_stop();
    e0 = gedges;
    at_rise();
    dbg_tck_en = 1'b1; #0.3;
    dbg_tck_en = 1'b0; #0.3;
    dbg_tck_en = 1'b1; #0.3;
    check(gclk == 1'b0, "R6", "gclk during high-phase raise", gclk, 0);
    check(gedges == e0, "R6", "no edge in high phase", gedges - e0, 0);
    at_rise();
    check(gclk == 1'b1, "R6", "gclk after low phase", gclk, 1);
    dbg_tck_en = 1'b0; #0.3;
    dbg_tck_en = 1'b1; #0.3;
    dbg_tck_en = 1'b0; #0.3;
    check(gclk == 1'b1, "R6", "gclk held during drop", gclk, 1);
    at_rise();
    check(gclk == 1'b0, "R6", "gclk stopped after fall", gclk, 0);
    check(gedges - e0 == 1, "R6", "single pulse", gedges - e0, 1);
  endtask

  initial begin
    test_reset();
    test_stop();
    test_standby_low();
    test_wake(0);
    test_wake(1);
    test_wake(2);
    test_dbg_comb();
    test_dbg_high_phase();
    at_rise();
    check(bad_rise == 0, "R7", "gclk rises with clk low", bad_rise, 0);
    check(bad_width == 0, "R7", "short gclk pulses", bad_width, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule